// File: doc/BRIEF.md
# Stereo DC-Removal Stage with Freezable Offset

This block removes the DC component from a pair of decimated, signed audio streams (left and right). Each channel keeps a running estimate of its own DC level in a first-order leaky integrator. The block subtracts the integer part of that estimate from every incoming sample and saturates the difference to the sample width.

A freeze input stops the integrator from updating. The held estimate is still subtracted from every sample, so the stage then acts as a fixed-offset remover. This supports system offset calibration: run with the integrator live until it settles, then assert freeze to lock in the measured offset. Releasing freeze resumes integration from the held value.

With the default shift of 13, the corner sits near 1 Hz at a 48 kHz sample rate and scales with the sample rate. The settling time is on the order of 10^5 samples.

Top module: `dc_blocker`

## Requirements
- R1: While reset is asserted and after it is released, `valid_o` is 0, both outputs are 0 and both offset estimates are 0, so the first sample after reset passes through unchanged.
- R2: On each accepted sample (`valid_i`=1, `freeze_i`=0), each channel updates its accumulator as acc := acc + (((x << FRAC_W) - acc) >>> SHIFT_K), where >>> is an arithmetic shift that rounds toward minus infinity. The estimate is floor(acc / 2^FRAC_W).
- R3: While `freeze_i`=1, the accumulators do not change, and the held estimate is still subtracted from every sample. When `freeze_i` returns to 0, updating resumes from the held value.
- R4: Each output equals its input minus that channel's estimate from before the sample's own update. The result is clamped to [-2^(DATA_W-1), 2^(DATA_W-1)-1] and never wraps.
- R5: `valid_o` is 1 in the cycle after a cycle with `valid_i`=1, and 0 in the cycle after a cycle with `valid_i`=0. The outputs change at that same edge.
- R6: In a cycle with `valid_i`=0, the estimates and both data outputs keep their values, whatever the data and freeze inputs do.
- R7: Left and right channels are independent: one channel's data never affects the other's estimate or output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Sample strobe for both channels |
| freeze_i | input | 1 | 1 holds both offset estimates |
| data_l_i | input | DATA_W | Left sample, two's complement |
| data_r_i | input | DATA_W | Right sample, two's complement |
| valid_o | output | 1 | Output sample strobe |
| data_l_o | output | DATA_W | Corrected left sample |
| data_r_o | output | DATA_W | Corrected right sample |

## Verification
Every corrected sample and its strobe are due exactly one clock edge after the edge that accepts the input sample. The estimate update from that sample first shows in the output of the next accepted sample.

The bench drives inputs on the falling edge and drops `valid_i` at the following falling edge. At that same falling edge, half a period after the capturing edge, it compares both outputs and the strobe. During idle cycles it samples the outputs at every falling edge to confirm they hold.

// File: rtl/dc_blocker_pkg.sv
package dc_blocker_pkg;
  localparam int unsigned NUM_CH = 2;
  typedef enum int unsigned {CH_L = 0, CH_R = 1} ch_e;
endpackage

// File: rtl/dcb_estimator.sv
// Leaky-integrator DC estimate, one channel.
module dcb_estimator #(
  parameter int unsigned DATA_W  = 24,
  parameter int unsigned SHIFT_K = 13,
  parameter int unsigned FRAC_W  = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              upd_i,
  input  logic [DATA_W-1:0] x_i,
  output logic [DATA_W-1:0] est_o
);
  localparam int unsigned ACC_W = DATA_W + FRAC_W;
  localparam int unsigned DIF_W = ACC_W + 1;

  logic signed [ACC_W-1:0] acc_q;
  logic signed [DIF_W-1:0] x_ext, acc_ext, diff, step, sum;

  always_comb begin
    x_ext   = $signed({x_i[DATA_W-1], x_i, {FRAC_W{1'b0}}});
    acc_ext = $signed({acc_q[ACC_W-1], acc_q});
    diff    = x_ext - acc_ext;
    step    = diff >>> SHIFT_K;
    sum     = acc_ext + step;
  end

  // sum is a convex mix of acc and x, so it fits in ACC_W
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    acc_q <= '0;
    else if (upd_i) acc_q <= sum[ACC_W-1:0];
  end

  assign est_o = acc_q[ACC_W-1:FRAC_W];
endmodule

// File: rtl/dcb_sat_sub.sv
// y = x - e, clamped to DATA_W signed range.
module dcb_sat_sub #(
  parameter int unsigned DATA_W = 24
) (
  input  logic [DATA_W-1:0] x_i,
  input  logic [DATA_W-1:0] e_i,
  output logic [DATA_W-1:0] y_o
);
  logic [DATA_W:0] d;
  localparam logic [DATA_W-1:0] MAX_V = {1'b0, {(DATA_W-1){1'b1}}};
  localparam logic [DATA_W-1:0] MIN_V = {1'b1, {(DATA_W-1){1'b0}}};

  always_comb begin
    d = {x_i[DATA_W-1], x_i} - {e_i[DATA_W-1], e_i};
    unique case (d[DATA_W:DATA_W-1])
      2'b01:   y_o = MAX_V;
      2'b10:   y_o = MIN_V;
      default: y_o = d[DATA_W-1:0];
    endcase
  end
endmodule

// File: rtl/dcb_channel.sv
module dcb_channel #(
  parameter int unsigned DATA_W  = 24,
  parameter int unsigned SHIFT_K = 13,
  parameter int unsigned FRAC_W  = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic              freeze_i,
  input  logic [DATA_W-1:0] x_i,
  output logic [DATA_W-1:0] y_o,
  output logic [DATA_W-1:0] est_o
);
  logic [DATA_W-1:0] est, y_d, y_q;

  dcb_estimator #(.DATA_W(DATA_W), .SHIFT_K(SHIFT_K), .FRAC_W(FRAC_W)) u_est (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .upd_i (valid_i & ~freeze_i),
    .x_i   (x_i),
    .est_o (est)
  );

  dcb_sat_sub #(.DATA_W(DATA_W)) u_sub (
    .x_i(x_i),
    .e_i(est),
    .y_o(y_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      y_q <= '0;
    else if (valid_i) y_q <= y_d;
  end

  assign y_o   = y_q;
  assign est_o = est;
endmodule

// File: rtl/dc_blocker.sv
module dc_blocker
  import dc_blocker_pkg::*;
#(
  parameter int unsigned DATA_W  = 24,
  parameter int unsigned SHIFT_K = 13,
  parameter int unsigned FRAC_W  = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic              freeze_i,
  input  logic [DATA_W-1:0] data_l_i,
  input  logic [DATA_W-1:0] data_r_i,
  output logic              valid_o,
  output logic [DATA_W-1:0] data_l_o,
  output logic [DATA_W-1:0] data_r_o
);
  logic [NUM_CH-1:0][DATA_W-1:0] x_w, y_w, est_w;
  logic valid_q;

  assign x_w[CH_L] = data_l_i;
  assign x_w[CH_R] = data_r_i;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    dcb_channel #(.DATA_W(DATA_W), .SHIFT_K(SHIFT_K), .FRAC_W(FRAC_W)) u_ch (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .valid_i (valid_i),
      .freeze_i(freeze_i),
      .x_i     (x_w[c]),
      .y_o     (y_w[c]),
      .est_o   (est_w[c])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) valid_q <= 1'b0;
    else         valid_q <= valid_i;
  end

  assign valid_o  = valid_q;
  assign data_l_o = y_w[CH_L];
  assign data_r_o = y_w[CH_R];
endmodule

// File: rtl/dc_blocker_chk.sv
module dc_blocker_chk #(
  parameter int unsigned DATA_W = 24,
  parameter int unsigned NCH    = 2
) (
  input logic                       clk_i,
  input logic                       rst_ni,
  input logic                       valid_i,
  input logic                       freeze_i,
  input logic [DATA_W-1:0]          data_l_i,
  input logic [DATA_W-1:0]          data_r_i,
  input logic                       valid_o,
  input logic [DATA_W-1:0]          data_l_o,
  input logic [DATA_W-1:0]          data_r_o,
  input logic [NCH-1:0][DATA_W-1:0] est_i
);
  a_r5_valid_rise: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o);
  a_r5_valid_fall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !valid_o);
  a_r6_idle_out_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> ($stable(data_l_o) && $stable(data_r_o)));
  a_r6_idle_est_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(est_i));
  a_r3_freeze_est_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    freeze_i |=> $stable(est_i));
  a_r4_sign_l: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && ($signed(data_l_i) >= $signed(est_i[0]))) |=> !data_l_o[DATA_W-1]);
  a_r4_sign_r: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && ($signed(data_r_i) >= $signed(est_i[1]))) |=> !data_r_o[DATA_W-1]);
endmodule

bind dc_blocker dc_blocker_chk #(.DATA_W(DATA_W), .NCH(dc_blocker_pkg::NUM_CH)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .valid_i (valid_i),
  .freeze_i(freeze_i),
  .data_l_i(data_l_i),
  .data_r_i(data_r_i),
  .valid_o (valid_o),
  .data_l_o(data_l_o),
  .data_r_o(data_r_o),
  .est_i   (est_w)
);

// File: tb/sim_dc_blocker.sv
module sim_dc_blocker;
  localparam int W = 24;
  localparam int K = 4;
  localparam int F = 8;
  localparam longint MAXV = (64'sd1 <<< (W-1)) - 1;
  localparam longint MINV = -(64'sd1 <<< (W-1));

  logic clk = 0, rst_ni = 0, valid_i = 0, freeze_i = 0;
  logic [W-1:0] data_l_i = '0, data_r_i = '0, data_l_o, data_r_o;
  logic valid_o;
  int checks = 0, failures = 0;
  bit done = 0;
  longint acc_l, acc_r;

  always #2 clk = ~clk;

  dc_blocker #(.DATA_W(W), .SHIFT_K(K), .FRAC_W(F)) u0 (
    .clk_i(clk), .rst_ni(rst_ni), .valid_i(valid_i), .freeze_i(freeze_i),
    .data_l_i(data_l_i), .data_r_i(data_r_i),
    .valid_o(valid_o), .data_l_o(data_l_o), .data_r_o(data_r_o)
  );

  // stimulus / expected table: xl, xr, freeze, yl, yr (R2 R3 R4 R7)
  localparam int NV = 7;
  localparam int TXL[NV] = '{1000, 1000, -500, 0, 100, 82, 0};
  localparam int TXR[NV] = '{-2000, 0, 300, 0, -92, 8, 0};
  localparam bit TFZ[NV] = '{0, 0, 0, 1, 1, 0, 0};
  localparam int TYL[NV] = '{1000, 938, -621, -82, 18, 0, -82};
  localparam int TYR[NV] = '{-2000, 125, 418, 92, 0, 100, 85};

  task automatic chk(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic longint sx(input logic [W-1:0] v);
    return longint'($signed(v));
  endfunction

  task automatic model(input longint x, input bit fz, inout longint acc, output longint y);
    longint est;
    est = acc >>> F;
    y = x - est;
    if (y > MAXV) y = MAXV;
    if (y < MINV) y = MINV;
    if (!fz) acc = acc + (((x <<< F) - acc) >>> K);
  endtask

  // drive at falling edge, check at next falling edge
  task automatic put(input longint xl, input longint xr, input bit fz,
                     output longint yl, output longint yr);
    valid_i = 1; freeze_i = fz;
    data_l_i = W'(xl); data_r_i = W'(xr);
    @(negedge clk);
    valid_i = 0;
    chk("R5 valid_o after sample", longint'(valid_o), 1);
    yl = sx(data_l_o); yr = sx(data_r_o);
  endtask

  task automatic put_model(input string req, input longint xl, input longint xr, input bit fz);
    longint yl, yr, el, er;
    model(xl, fz, acc_l, el);
    model(xr, fz, acc_r, er);
    put(xl, xr, fz, yl, yr);
    chk({req, " left"}, yl, el);
    chk({req, " right"}, yr, er);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_ni = 0; valid_i = 0; freeze_i = 0;
    @(negedge clk); @(negedge clk);
    chk("R1 valid_o in reset", longint'(valid_o), 0);
    chk("R1 data_l_o in reset", sx(data_l_o), 0);
    chk("R1 data_r_o in reset", sx(data_r_o), 0);
    rst_ni = 1;
    acc_l = 0; acc_r = 0;
    @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    longint yl, yr, hl, hr;
    do_reset();
    chk("R1 valid_o after reset", longint'(valid_o), 0);

    // table walk
    for (int i = 0; i < NV; i++) begin
      put(TXL[i], TXR[i], TFZ[i], yl, yr);
      chk($sformatf("R2/R3/R4 row %0d left", i), yl, TYL[i]);
      chk($sformatf("R7 row %0d right", i), yr, TYR[i]);
      chk("R5 valid_o drops", longint'(valid_o), 1);
      @(negedge clk);
      chk("R5 valid_o low after idle", longint'(valid_o), 0);
    end

    // R1: mid-run reset clears estimate
    do_reset();
    put_model("R1 first sample passes", 12345, -777, 0);

    // R6: idle cycles with toggling inputs change nothing
    put_model("R2 warmup", 40000, -30000, 0);
    put_model("R2 warmup", 40000, -30000, 0);
    hl = sx(data_l_o); hr = sx(data_r_o);
    for (int i = 0; i < 4; i++) begin
      data_l_i = W'(i * 999); data_r_i = W'(-i * 555); freeze_i = i[0];
      @(negedge clk);
      chk("R6 idle valid_o", longint'(valid_o), 0);
      chk("R6 idle left hold", sx(data_l_o), hl);
      chk("R6 idle right hold", sx(data_r_o), hr);
    end
    put_model("R6 estimate untouched by idle", 40000, -30000, 0);

    // R3: freeze then release resumes from held value
    for (int i = 0; i < 3; i++) put_model("R3 frozen", 5000 * i, -7000, 1);
    for (int i = 0; i < 3; i++) put_model("R3 resumed", 40000, -30000, 0);

    // R7: right stays zero while left carries signal
    do_reset();
    for (int i = 0; i < 5; i++) begin
      put(3000, 0, 0, yl, yr);
      chk("R7 right unaffected", yr, 0);
    end

    // R4: saturation both directions
    do_reset();
    for (int i = 0; i < 150; i++) put_model("R2 long run", MAXV, MINV, 0);
    put(MINV, MAXV, 1, yl, yr);
    chk("R4 negative clamp left", yl, MINV);
    chk("R4 positive clamp right", yr, MAXV);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule